// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block turns a 21-bit parallel video word into three serial data lanes plus one forwarded clock lane. The word holds 18 colour bits and three timing bits: line sync, frame sync and data-ready. One word is captured in every pixel clock period. A bit clock supplied from outside runs at exactly seven times the pixel rate, and in that domain each lane sends seven bits per pixel period. The serializer takes its framing from the pixel clock: it samples the pixel clock in the bit domain and realigns a mod-7 phase counter on every detected rising edge. Because of this, no fixed phase between the two clocks needs to be known in advance.

A control state machine in the bit domain decides whether the lanes may carry data. It has four states. ST_OFF holds while the synchronized active-low power-down input is asserted. ST_LOST is entered from ST_OFF when power returns, or from ST_ACQ or ST_RUN when the pixel clock has been silent for too long. ST_ACQ counts good pixel periods and is entered from ST_LOST on a pixel rising edge. ST_RUN is entered from ST_ACQ at the second good rising edge. The transitions are named off_enter, pwr_up, pix_seen, acq_lost, acq_done and run_lost. Every state except ST_RUN forces all four lanes to a static low. A pin selects whether the pixel word is captured on the rising or the falling pixel clock edge.

Top module: `vsl_serlink`

## Requirements
- R1: The word {data_rdy, frame_sync, line_sync, color[17:0]} (bit 20 down to bit 0) is captured once per pixel period. The word captured in pixel period m goes out in the serial slot that starts three bit-clock edges after pixel rising edge m+2.
- R2: Lane i carries word bits [7i+6:7i], most significant bit first. Lane 0 therefore holds colour 6..0, lane 1 colour 13..7, and lane 2 sends data_rdy, frame_sync, line_sync, then colour 17..14. Every load of the shift registers in ST_RUN coincides with a detected pixel rising edge.
- R3: The clock lane repeats 1100011 (first bit sent on the left) in every slot, with its first bit in the same bit time as the first data bit.
- R4: With edge_sel=1 the word is taken on the pixel rising edge that closes the period. With edge_sel=0 it is taken on the falling edge in the middle of the period.
- R5: If the synchronized pixel clock shows no transition for 16 bit-clock cycles while power is on, the machine takes run_lost or acq_lost into ST_LOST, and all four lanes go low.
- R6: After a loss, the lanes stay low until the second pixel rising edge that follows the first edge seen (two good periods). Output then restarts at a word boundary with the word captured in the first good period.
- R7: Driving pwr_n low brings all four lanes to low on the third bit-clock edge after the change. Releasing it returns through ST_LOST under the same rule as R6.
- R8: While rst_n is low, and until the first word is ready after reset, all four lanes are low.
- R9: A pixel clock held high for four and low for three bit cycles never triggers a loss, and the data stream stays continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock |
| pwr_n | input | 1 | Active-low power-down request |
| edge_sel | input | 1 | 1 selects rising-edge capture, 0 selects falling-edge capture |
| color | input | 18 | Colour bits |
| line_sync | input | 1 | Line timing bit |
| frame_sync | input | 1 | Frame timing bit |
| data_rdy | input | 1 | Data-ready timing bit |
| lane_d | output | 3 | Serial data lanes |
| lane_clk | output | 1 | Forwarded clock lane |

## Verification
The bench drives data that changes between the falling edge and the next rising edge. A design that ignored edge_sel, or that swapped the two capture registers, would therefore send the wrong word in one of the two modes. It stops the pixel clock for six periods and then restarts it. A detector that fired too late would leak stale words into the silent slots, and one that resumed too early, or off a word boundary, would send a partial or shifted word. Power-down is checked on the exact bit where the lanes must fall, which catches an extra or missing synchronizer stage. Lane order and bit order are compared on every bit, so a reversed shift or swapped lanes fails at once.

// File: rtl/vsl_pkg.sv
package vsl_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOST = 2'd1,
        ST_ACQ  = 2'd2,
        ST_RUN  = 2'd3
    } link_state_t;

    localparam int CTRL_BITS = 3;

endpackage

// File: rtl/vsl_capture.sv
module vsl_capture #(
    parameter int WORD_W = 21
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic              edge_sel,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] cap_o
);

    logic [WORD_W-1:0] rise_q;
    logic [WORD_W-1:0] fall_q;

    // word taken at the closing rising edge of the pixel period
    always_ff @(posedge pix_clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
        end else begin
            rise_q <= din;
        end
    end

    // word taken at the mid-period falling edge
    always_ff @(negedge pix_clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= din;
        end
    end

    always_comb begin
        cap_o = edge_sel ? rise_q : fall_q;
    end

endmodule

// File: rtl/vsl_clkmon.sv
module vsl_clkmon
    import vsl_pkg::*;
#(
    parameter int LOSS_CYC = 16,
    parameter int GOOD_PER = 2
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic pwr_n,
    output logic rise_o,
    output logic run_o
);

    localparam int IDLE_W = $clog2(LOSS_CYC);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(LOSS_CYC - 1);
    localparam int GOOD_W = $clog2(GOOD_PER + 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_PER - 1);

    logic [2:0]        pix_s_q;
    logic [1:0]        pwr_s_q;
    logic              pd_ok;
    logic              toggle;
    logic              timeout;
    logic [IDLE_W-1:0] idle_q;
    logic [GOOD_W-1:0] good_q;
    link_state_t       state_q;
    link_state_t       state_d;

    // pixel clock and power request brought into the bit domain
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_s_q <= '0;
            pwr_s_q <= '0;
        end else begin
            pix_s_q <= {pix_s_q[1:0], pix_clk};
            pwr_s_q <= {pwr_s_q[0], pwr_n};
        end
    end

    assign pd_ok  = pwr_s_q[1];
    assign toggle = pix_s_q[1] ^ pix_s_q[2];
    assign rise_o = pix_s_q[1] & ~pix_s_q[2];

    // cycles since the last pixel clock transition, saturating
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (toggle) begin
            idle_q <= '0;
        end else if (idle_q != IDLE_LAST) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign timeout = (idle_q == IDLE_LAST) && !toggle;

    // good pixel periods seen while acquiring
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
        end else if (state_q != ST_ACQ) begin
            good_q <= '0;
        end else if (rise_o && good_q != GOOD_LAST) begin
            good_q <= good_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!pd_ok) begin
            state_d = ST_OFF;                       // off_enter
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_LOST;         // pwr_up
                ST_LOST: if (rise_o) state_d = ST_ACQ;   // pix_seen
                ST_ACQ: begin
                    if (timeout) begin
                        state_d = ST_LOST;          // acq_lost
                    end else if (rise_o && good_q == GOOD_LAST) begin
                        state_d = ST_RUN;           // acq_done
                    end
                end
                ST_RUN:  if (timeout) state_d = ST_LOST; // run_lost
                default: state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        run_o = (state_q == ST_RUN);
    end

    // R5: a silent pixel clock while powered ends in ST_LOST
    assert_loss_declared_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pd_ok && state_q != ST_OFF && timeout) |=> (state_q == ST_LOST));

    // R7: a synchronized power-down request always lands in ST_OFF
    assert_pd_off_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!pd_ok) |=> (state_q == ST_OFF));

endmodule

// File: rtl/vsl_serializer.sv
module vsl_serializer #(
    parameter int              LANES   = 3,
    parameter int              BITS    = 7,
    parameter logic [BITS-1:0] CLK_PAT = 7'b1100011
) (
    input  logic                  bit_clk,
    input  logic                  rst_n,
    input  logic                  rise_i,
    input  logic                  run_i,
    input  logic [LANES*BITS-1:0] word_i,
    output logic [LANES-1:0]      lane_o,
    output logic                  lane_clk_o
);

    localparam int WORD_W = LANES * BITS;
    localparam int PH_W   = $clog2(BITS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BITS - 1);

    logic [PH_W-1:0]   ph_q;
    logic              load;
    logic [WORD_W-1:0] hold_q;
    logic [BITS-1:0]   clk_sh_q;

    // mod-BITS phase counter, realigned on each pixel rising edge
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (rise_i) begin
            ph_q <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign load = (ph_q == PH_LAST);

    // first stage of the handoff: held for one pixel period
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rise_i) begin
            hold_q <= word_i;
        end
    end

    // second stage: one shift register per data lane
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic [BITS-1:0] sh_q;
        always_ff @(posedge bit_clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else if (load) begin
                sh_q <= hold_q[gi*BITS +: BITS];
            end else begin
                sh_q <= {sh_q[BITS-2:0], 1'b0};
            end
        end
        assign lane_o[gi] = run_i & sh_q[BITS-1];
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sh_q <= '0;
        end else if (load) begin
            clk_sh_q <= CLK_PAT;
        end else begin
            clk_sh_q <= {clk_sh_q[BITS-2:0], 1'b0};
        end
    end

    assign lane_clk_o = run_i & clk_sh_q[BITS-1];

    // R2: while running, every pixel rising edge falls on a word boundary
    assert_load_on_edge_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (run_i && rise_i) |-> load);

    // R3: the clock lane opens every slot with a high bit
    assert_clk_lead_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (run_i && load) |=> (!run_i || lane_clk_o));

endmodule

// File: rtl/vsl_serlink.sv
module vsl_serlink
    import vsl_pkg::*;
#(
    parameter int              LANES    = 3,
    parameter int              BITS     = 7,
    parameter int              LOSS_CYC = 16,
    parameter int              GOOD_PER = 2,
    parameter logic [BITS-1:0] CLK_PAT  = 7'b1100011
) (
    input  logic                            bit_clk,
    input  logic                            rst_n,
    input  logic                            pix_clk,
    input  logic                            pwr_n,
    input  logic                            edge_sel,
    input  logic [LANES*BITS-CTRL_BITS-1:0] color,
    input  logic                            line_sync,
    input  logic                            frame_sync,
    input  logic                            data_rdy,
    output logic [LANES-1:0]                lane_d,
    output logic                            lane_clk
);

    localparam int WORD_W = LANES * BITS;

    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] cap_word;
    logic              rise;
    logic              run;

    assign word_in = {data_rdy, frame_sync, line_sync, color};

    vsl_capture #(
        .WORD_W (WORD_W)
    ) u_cap (
        .pix_clk  (pix_clk),
        .rst_n    (rst_n),
        .edge_sel (edge_sel),
        .din      (word_in),
        .cap_o    (cap_word)
    );

    vsl_clkmon #(
        .LOSS_CYC (LOSS_CYC),
        .GOOD_PER (GOOD_PER)
    ) u_mon (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .pix_clk (pix_clk),
        .pwr_n   (pwr_n),
        .rise_o  (rise),
        .run_o   (run)
    );

    vsl_serializer #(
        .LANES   (LANES),
        .BITS    (BITS),
        .CLK_PAT (CLK_PAT)
    ) u_ser (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .run_i      (run),
        .word_i     (cap_word),
        .lane_o     (lane_d),
        .lane_clk_o (lane_clk)
    );

endmodule

// File: tb/sim_vsl_serlink.sv
module sim_vsl_serlink;

    localparam int BIT_PERIOD = 10;
    localparam int NPER       = 66;
    localparam int WW         = 21;
    localparam logic [6:0] PAT = 7'b1100011;

    logic        bit_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_clk = 1'b0;
    logic        pwr_n = 1'b1;
    logic        edge_sel = 1'b1;
    logic [17:0] color = '0;
    logic        line_sync = 1'b0;
    logic        frame_sync = 1'b0;
    logic        data_rdy = 1'b0;
    logic [2:0]  lane_d;
    logic        lane_clk;

    logic [WW-1:0] exp_w [0:NPER+2];
    int            tag   [0:NPER+2];
    string         lbl   [0:NPER+2];
    int            cyc = 0;
    int            checks = 0;
    int            fails = 0;
    bit            done = 1'b0;

    always #(BIT_PERIOD/2) bit_clk = ~bit_clk;

    vsl_serlink u0 (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .pix_clk    (pix_clk),
        .pwr_n      (pwr_n),
        .edge_sel   (edge_sel),
        .color      (color),
        .line_sync  (line_sync),
        .frame_sync (frame_sync),
        .data_rdy   (data_rdy),
        .lane_d     (lane_d),
        .lane_clk   (lane_clk)
    );

    function automatic logic [WW-1:0] gen_word(input int m);
        logic [31:0] v;
        v = (32'(m) * 32'h0009E37B) ^ (32'(m) << 13) ^ 32'h0015A3C6;
        return v[WW-1:0];
    endfunction

    function automatic bit sel_for(input int m);
        return !(m >= 21 && m <= 34);
    endfunction

    function automatic bit glitch_for(input int m);
        return (m >= 13 && m <= 30);
    endfunction

    function automatic bit gated(input int m);
        return (m >= 36 && m <= 41);
    endfunction

    // tag: 0 all low, 1 word, 2 unchecked, 3 first bit word then low
    task automatic check_out(input int n);
        int j, s, t;
        string l;
        logic [3:0] expv, got;
        j = 0; s = 0;
        if (n < 3) begin
            t = 0; l = "R8";
        end else begin
            j = (n - 3) / 7;
            s = (n - 3) % 7;
            t = tag[j];
            l = lbl[j];
        end
        if (t == 2) return;
        expv = 4'b0000;
        if (t == 1 || (t == 3 && s == 0)) begin
            for (int i = 0; i < 3; i++) expv[i] = exp_w[j-2][7*i + 6 - s];
            expv[3] = PAT[6 - s];
        end
        got = {lane_clk, lane_d};
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s cycle %0d slot %0d bit %0d: got %b expected %b",
                     l, n, j, s, got, expv);
        end
    endtask

    task automatic drive(input int n);
        int m, p;
        logic [WW-1:0] w;
        m = n / 7;
        p = n % 7;
        if (n == 5) rst_n = 1'b1;
        w = gen_word(m);
        case (p)
            0: if (!gated(m)) pix_clk = 1'b1;
            1: begin
                {data_rdy, frame_sync, line_sync, color} = w;
                exp_w[m] = (glitch_for(m) && sel_for(m)) ? ~w : w;
                if (m == 50) pwr_n = 1'b0;
                if (m == 56) pwr_n = 1'b1;
            end
            4: begin
                pix_clk  = 1'b0;
                edge_sel = sel_for(m);
            end
            5: if (glitch_for(m)) {data_rdy, frame_sync, line_sync, color} = ~w;
            default: ;
        endcase
    endtask

    initial begin
        for (int j = 0; j <= NPER + 2; j++) begin
            exp_w[j] = '0;
            tag[j]   = 1;
            lbl[j]   = "R1 R2 R3 R9";
        end
        for (int j = 0; j <= 2; j++) begin tag[j] = 0; lbl[j] = "R8"; end
        for (int j = 15; j <= 32; j++) lbl[j] = "R4";
        tag[36] = 2; tag[37] = 2;
        for (int j = 38; j <= 41; j++) begin tag[j] = 0; lbl[j] = "R5"; end
        for (int j = 42; j <= 43; j++) begin tag[j] = 0; lbl[j] = "R6"; end
        lbl[44] = "R6";
        tag[50] = 3; lbl[50] = "R7";
        for (int j = 51; j <= 58; j++) begin tag[j] = 0; lbl[j] = "R7"; end
        lbl[59] = "R7";

        for (int k = 0; k < NPER * 7; k++) begin
            @(posedge bit_clk);
            cyc++;
            @(negedge bit_clk);
            if (done) break;
            check_out(cyc);
            drive(cyc);
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(BIT_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d (all requirements)", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule